// File: doc/BRIEF.md
# SAR Conversion Cycle Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Each clock edge ends one numbered period of a fixed conversion cycle. The first periods keep the external sampler tracking. The periods after them hold the sample and resolve one result bit each, from the most significant bit to the least. The block shows the comparator a trial code. It reads back a single bit, `cmp_ge`, which is high when the held input is at or above that trial level.

The block can run without a break, one cycle after another, while the active-low start input is held low. If start is high when period 2 ends, and no start was taken at the end of period 1, the sequencer waits in period 2 and keeps tracking. A later low on start lets the cycle go on. The ready flag goes high as the finished code is loaded. It goes low at the start of period 2 or when the next start is taken, whichever comes later. A separate active-low clear input can force it low at any time.

Top module: `sar_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `period_o` is 2, `track_o` is 1, `rdy_o` is 0 and `result_o` is 0.
- R2: `track_o` is 1 in periods 1 to 3 and 0 in periods 4 to 13.
- R3: Every edge advances `period_o` by one, except the edge that ends period 13, which goes to 1, and a stall in period 2. With `start_n` held low the sequence runs 3, 4, …, 13, 1, 2 and repeats every 13 clocks.
- R4: In period 2, an edge that sees `start_n` high, with no start taken at the end of period 1, leaves `period_o` at 2.
- R5: A low `start_n` at the edge that ends period 1 is remembered. The next edge moves period 2 to 3 even if `start_n` has gone high again.
- R6: In period 2, an edge that sees `start_n` low moves to period 3 and drives `rdy_o` low.
- R7: In period 4 the trial code is 0x200. In each hold period, bit (13 − period) of the trial code is kept only if `cmp_ge` is 1, and the next lower bit is set to 1. With `cmp_ge` equal to input ≥ trial, the result equals the input, for every input from 0x000 to 0x3FF.
- R8: `result_o` changes only at the edge that ends period 13. It is stable through every other period.
- R9: `rdy_o` rises only at the edge into period 1, and it does rise there when `rdy_clr_n` is high at that edge.
- R10: `rdy_o` falls at the edge into period 2 when `start_n` is low at that edge. Otherwise it stays high through a stall in period 2 until a start is taken. It is 0 in periods 3 to 13.
- R11: A low `rdy_clr_n` at an edge makes `rdy_o` 0 after that edge, and it also blocks the rise at the entry to period 1. Releasing `rdy_clr_n` does not raise `rdy_o` until the next entry to period 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_n | input | 1 | Active-low start request |
| rdy_clr_n | input | 1 | Active-low clear for the ready flag |
| cmp_ge | input | 1 | Comparator: held input at or above trial level |
| track_o | output | 1 | High while the sampler tracks |
| trial_code_o | output | 10 | Trial code presented to the comparator |
| period_o | output | 4 | Current period number, 1 to 13 |
| result_o | output | 10 | Last completed conversion code |
| rdy_o | output | 1 | Data-ready flag |

## Verification
The properties assume that `start_n` and `rdy_clr_n` are synchronous to `clk`. They also assume that `cmp_ge` depends only on the trial code shown in the same period. The bench drives both control inputs only at falling edges. It derives `cmp_ge` combinationally from a stored input value and the trial code, so each rule sees a settled level at the rising edge. The input value changes only in period 2, which keeps the comparator consistent across the ten hold periods of each conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Coarse phase of the conversion cycle, decoded from the period number
  typedef enum logic [1:0] {
    PH_OPEN = 2'd0,  // period 1: tracking restarts, code published
    PH_PARK = 2'd1,  // period 2: possible stall point
    PH_TRK  = 2'd2,  // remaining tracking periods
    PH_HOLD = 2'd3   // one result bit per period
  } seq_phase_e;

  function automatic seq_phase_e phase_of(input int unsigned period,
                                          input int unsigned track_periods);
    if (period == 1)                 return PH_OPEN;
    else if (period == 2)            return PH_PARK;
    else if (period <= track_periods) return PH_TRK;
    else                             return PH_HOLD;
  endfunction

endpackage

// File: rtl/sar_period_ctrl.sv
module sar_period_ctrl #(
  parameter int NUM_PERIODS = 13,
  localparam int PW = $clog2(NUM_PERIODS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  output logic [PW-1:0] period_q,
  output logic          leave_park
);

  localparam logic [PW-1:0] P_OPEN = PW'(1);
  localparam logic [PW-1:0] P_PARK = PW'(2);
  localparam logic [PW-1:0] P_LAST = PW'(NUM_PERIODS);

  logic [PW-1:0] period_d;
  logic          period_en;
  logic          pend_q, pend_d;

  always_comb begin
    leave_park = (period_q == P_PARK) && (!start_n || pend_q);
    period_d   = period_q;
    period_en  = 1'b1;
    pend_d     = pend_q;

    if (period_q == P_LAST) begin
      period_d = P_OPEN;
    end else if (period_q == P_PARK) begin
      period_en = leave_park;
      period_d  = P_PARK + PW'(1);
      pend_d    = 1'b0;
    end else begin
      period_d = period_q + PW'(1);
    end

    // start taken at the close of period 1 is carried through period 2
    if ((period_q == P_OPEN) && !start_n) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= P_PARK;
      pend_q   <= 1'b0;
    end else begin
      if (period_en) period_q <= period_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_BITS      = 10,
  parameter int TRACK_PERIODS = 3,
  localparam int NUM_PERIODS  = TRACK_PERIODS + RES_BITS,
  localparam int PW           = $clog2(NUM_PERIODS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       period_i,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] trial_q,
  output logic [RES_BITS-1:0] result_q
);

  import sar_seq_pkg::*;

  localparam logic [PW-1:0] P_SEED = PW'(TRACK_PERIODS);
  localparam logic [PW-1:0] P_LAST = PW'(NUM_PERIODS);

  seq_phase_e          phase;
  int                  bit_pos;
  logic [RES_BITS-1:0] decided;
  logic [RES_BITS-1:0] trial_d;
  logic                trial_en;
  logic                result_en;

  assign phase   = phase_of(int'(period_i), TRACK_PERIODS);
  // period TRACK_PERIODS+1 resolves the top bit, the last period bit 0
  assign bit_pos = NUM_PERIODS - int'(period_i);

  for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
    always_comb begin
      if (b == bit_pos)          decided[b] = cmp_ge;
      else if (b + 1 == bit_pos) decided[b] = 1'b1;
      else                       decided[b] = trial_q[b];
    end
  end

  always_comb begin
    trial_d   = trial_q;
    trial_en  = 1'b0;
    result_en = 1'b0;
    if (period_i == P_SEED) begin
      trial_d  = {1'b1, {(RES_BITS-1){1'b0}}};
      trial_en = 1'b1;
    end else if (phase == PH_HOLD) begin
      trial_d   = decided;
      trial_en  = 1'b1;
      result_en = (period_i == P_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      if (trial_en)  trial_q  <= trial_d;
      if (result_en) result_q <= decided;
    end
  end

endmodule

// File: rtl/sar_ready_flag.sv
module sar_ready_flag #(
  parameter int NUM_PERIODS = 13,
  localparam int PW = $clog2(NUM_PERIODS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_i,
  input  logic          start_n,
  input  logic          leave_park,
  input  logic          rdy_clr_n,
  output logic          rdy_q
);

  localparam logic [PW-1:0] P_OPEN = PW'(1);
  localparam logic [PW-1:0] P_PARK = PW'(2);
  localparam logic [PW-1:0] P_LAST = PW'(NUM_PERIODS);

  logic rdy_d;

  always_comb begin
    if (!rdy_clr_n)                              rdy_d = 1'b0;
    else if (period_i == P_LAST)                 rdy_d = 1'b1;
    else if ((period_i == P_OPEN) && !start_n)   rdy_d = 1'b0;
    else if ((period_i == P_PARK) && leave_park) rdy_d = 1'b0;
    else                                         rdy_d = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

endmodule

// File: rtl/sar_cycle_seq.sv
module sar_cycle_seq #(
  parameter int  RES_BITS      = 10,
  parameter int  TRACK_PERIODS = 3,
  localparam int NUM_PERIODS   = TRACK_PERIODS + RES_BITS,
  localparam int PW            = $clog2(NUM_PERIODS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_n,
  input  logic                rdy_clr_n,
  input  logic                cmp_ge,
  output logic                track_o,
  output logic [RES_BITS-1:0] trial_code_o,
  output logic [PW-1:0]       period_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                rdy_o
);

  import sar_seq_pkg::*;

  logic [PW-1:0] period;
  logic          leave_park;
  seq_phase_e    phase;

  sar_period_ctrl #(.NUM_PERIODS(NUM_PERIODS)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_n    (start_n),
    .period_q   (period),
    .leave_park (leave_park)
  );

  sar_bit_engine #(.RES_BITS(RES_BITS), .TRACK_PERIODS(TRACK_PERIODS)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period),
    .cmp_ge   (cmp_ge),
    .trial_q  (trial_code_o),
    .result_q (result_o)
  );

  sar_ready_flag #(.NUM_PERIODS(NUM_PERIODS)) u_rdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_i   (period),
    .start_n    (start_n),
    .leave_park (leave_park),
    .rdy_clr_n  (rdy_clr_n),
    .rdy_q      (rdy_o)
  );

  assign phase    = phase_of(int'(period), TRACK_PERIODS);
  assign track_o  = (phase != PH_HOLD);
  assign period_o = period;

endmodule

// File: rtl/sar_cycle_seq_chk.sv
module sar_cycle_seq_chk #(
  parameter int  RES_BITS      = 10,
  parameter int  TRACK_PERIODS = 3,
  localparam int NUM_PERIODS   = TRACK_PERIODS + RES_BITS,
  localparam int PW            = $clog2(NUM_PERIODS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_n,
  input logic                rdy_clr_n,
  input logic                track_o,
  input logic [RES_BITS-1:0] trial_code_o,
  input logic [PW-1:0]       period_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                rdy_o
);

  localparam logic [PW-1:0]       P_OPEN = PW'(1);
  localparam logic [PW-1:0]       P_PARK = PW'(2);
  localparam logic [PW-1:0]       P_HOLD0 = PW'(TRACK_PERIODS + 1);
  localparam logic [PW-1:0]       P_LAST = PW'(NUM_PERIODS);
  localparam logic [RES_BITS-1:0] MSB_TRIAL = {1'b1, {(RES_BITS-1){1'b0}}};

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o >= P_OPEN) && (period_o <= P_LAST)); // R3
  AST_WRAP_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o == P_LAST) |=> (period_o == P_OPEN)); // R3
  AST_OPEN_TO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o == P_OPEN) |=> (period_o == P_PARK)); // R3
  AST_TRACK_IN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o == P_OPEN) |-> track_o); // R2
  AST_HOLD_AT_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o == P_HOLD0) |-> !track_o); // R2
  AST_PARK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_o == P_PARK) && start_n && ($past(period_o) == P_PARK)) |=> (period_o == P_PARK)); // R4
  AST_PARK_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_o == P_PARK) && !start_n) |=> ((period_o == P_PARK + PW'(1)) && !rdy_o)); // R6
  AST_MSB_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o == P_HOLD0) |-> (trial_code_o == MSB_TRIAL)); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (period_o != P_LAST) |=> $stable(result_o)); // R8
  AST_RDY_RISE_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> (period_o == P_OPEN)); // R9
  AST_RDY_KEPT_INTO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_o == P_OPEN) && start_n && rdy_clr_n && rdy_o) |=> rdy_o); // R10
  AST_RDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_clr_n |=> !rdy_o); // R11

endmodule

bind sar_cycle_seq sar_cycle_seq_chk #(
  .RES_BITS      (RES_BITS),
  .TRACK_PERIODS (TRACK_PERIODS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_n      (start_n),
  .rdy_clr_n    (rdy_clr_n),
  .track_o      (track_o),
  .trial_code_o (trial_code_o),
  .period_o     (period_o),
  .result_o     (result_o),
  .rdy_o        (rdy_o)
);

// File: tb/sar_cycle_seq_tb.sv
module sar_cycle_seq_tb_top;

  localparam int RB = 10;
  localparam int PW = 4;

  logic          clk;
  logic          rst_n;
  logic          start_n;
  logic          rdy_clr_n;
  logic          cmp_ge;
  logic          track_o;
  logic [RB-1:0] trial_code_o;
  logic [PW-1:0] period_o;
  logic [RB-1:0] result_o;
  logic          rdy_o;
  logic [RB-1:0] vin;

  int n_cmp = 0;
  int n_bad = 0;

  sar_cycle_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n      (start_n),
    .rdy_clr_n    (rdy_clr_n),
    .cmp_ge       (cmp_ge),
    .track_o      (track_o),
    .trial_code_o (trial_code_o),
    .period_o     (period_o),
    .result_o     (result_o),
    .rdy_o        (rdy_o)
  );

  // comparator model: held input at or above the trial level
  assign cmp_ge = (vin >= trial_code_o);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // caller stands at a falling edge in period 2 with the start level set
  task automatic run_conv(input int v, input bit keep_start, input bit clr_late);
    int held = 0;
    for (int k = 0; k < 12; k++) begin
      int ep;
      @(negedge clk);
      ep = (k < 11) ? k + 3 : 1;
      if (k == 0) begin
        held = int'(result_o);
        if (!keep_start) start_n = 1'b1;
      end
      check("R3 R5 period", int'(period_o), ep);
      check("R2 track", int'(track_o), (ep <= 3) ? 1 : 0);
      if (ep == 4) check("R7 msb trial", int'(trial_code_o), 1 << (RB - 1));
      if (ep != 1) begin
        check("R8 result held", int'(result_o), held);
        check("R6 R10 rdy low in cycle", int'(rdy_o), 0);
      end
      if (ep == 13 && clr_late) rdy_clr_n = 1'b0;
    end
    check("R7 result code", int'(result_o), v);
    check("R9 R11 rdy at period 1", int'(rdy_o), clr_late ? 0 : 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start_n   = 1'b1;
    rdy_clr_n = 1'b1;
    vin       = '0;
    repeat (3) @(negedge clk);
    check("R1 reset period", int'(period_o), 2);
    check("R1 reset track", int'(track_o), 1);
    check("R1 reset rdy", int'(rdy_o), 0);
    check("R1 reset result", int'(result_o), 0);
    rst_n = 1'b1;

    // parked after reset with start high
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 stall after reset", int'(period_o), 2);
      check("R4 track while parked", int'(track_o), 1);
    end

    // full sweep, free running with start held low
    for (int v = 0; v < (1 << RB); v++) begin
      vin     = RB'(v);
      start_n = 1'b0;
      run_conv(v, 1'b1, 1'b0);
      @(negedge clk);
      check("R3 back-to-back period 2", int'(period_o), 2);
      check("R10 rdy drops entering period 2", int'(rdy_o), 0);
    end

    // start seen at end of period 1 only, then released
    vin = RB'(600);
    start_n = 1'b0;
    run_conv(600, 1'b0, 1'b0);
    start_n = 1'b0;
    @(negedge clk);
    check("R10 rdy drops at period 2", int'(rdy_o), 0);
    check("R5 period 2 reached", int'(period_o), 2);
    start_n = 1'b1;
    vin = RB'(77);
    run_conv(77, 1'b0, 1'b0);

    // parked with rdy high, then resumed by start
    @(negedge clk);
    check("R10 rdy kept while parked", int'(rdy_o), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 parked period", int'(period_o), 2);
      check("R10 rdy still high", int'(rdy_o), 1);
    end
    vin = RB'(345);
    start_n = 1'b0;
    run_conv(345, 1'b0, 1'b0);

    // ready clear while parked
    @(negedge clk);
    check("R10 rdy high in park", int'(rdy_o), 1);
    rdy_clr_n = 1'b0;
    @(negedge clk);
    check("R11 rdy cleared", int'(rdy_o), 0);
    check("R11 period unaffected", int'(period_o), 2);
    rdy_clr_n = 1'b1;
    @(negedge clk);
    check("R11 no rise after release", int'(rdy_o), 0);

    // clear held through the entry to period 1
    vin = RB'(1023);
    start_n = 1'b0;
    run_conv(1023, 1'b0, 1'b1);
    rdy_clr_n = 1'b1;
    @(negedge clk);
    check("R11 rdy stays low", int'(rdy_o), 0);
    check("R4 parked after blocked rise", int'(period_o), 2);
    check("R8 result kept", int'(result_o), 1023);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule